// File: doc/BRIEF.md
# Fractional Baud Generator with Three Clocking Modes

This block derives serial-port timing from the system clock. In asynchronous mode it emits a one-cycle strobe at sixteen times the bit rate. The strobe spacing is a divisor that has a whole part and a fractional part in sixty-fourths. The fraction is realised by letting some strobe periods run one cycle longer than others, so the long-run average spacing equals the programmed value. In synchronous master mode the same counter drives a square serial clock whose half period is the whole part of the divisor. In synchronous slave mode the block takes an external serial clock, synchronises it to the system clock and forwards it. In that mode the divisor is not used.

The divisor is loaded one byte at a time through a small write port: a low byte, a high byte and a fraction byte. A new divisor is taken up only when the period in progress ends, so the outputs never show a shortened pulse. Changing the mode clears the counter and the fractional phase, and each mode starts from a clean state.

Top module: `fracbaud_gen`

## Requirements
- R1: While `rst_n` is low, `os_tick` and `sclk_out` are 0. Reset clears the divisor registers, so after reset no tick appears until a nonzero divisor is written.
- R2: A write with `wr_en`=1 stores `wr_data` as follows: `wr_sel`=0 loads divisor bits 7:0, `wr_sel`=1 loads divisor bits 15:8, and `wr_sel`=2 loads the fraction from `wr_data[5:0]` (bits 7:6 are dropped). `wr_sel`=3 changes nothing.
- R3: In asynchronous mode (`mode_sel`=0) with divisor D>1 and fraction F, `os_tick` is a one-cycle pulse. The first period after the mode is entered lasts D cycles. The n-th spacing after that (n=1,2,...) is D + floor(nF/64) - floor((n-1)F/64) cycles, so the average spacing is D + F/64.
- R4: With D=1 in asynchronous mode the fraction is ignored and `os_tick` is high on every cycle.
- R5: With D=0, no tick is produced in asynchronous mode and `sclk_out` stays low in master mode.
- R6: In synchronous master mode (`mode_sel`=1), `sclk_out` starts low and toggles every D cycles. The fraction has no effect.
- R7: A divisor write made during a period does not alter that period. The period that starts next uses the new value.
- R8: In synchronous slave mode (`mode_sel`=2), `sclk_out` equals `ext_sclk` delayed by SYNC_STAGES+1 cycles (3 by default), and `os_tick` stays low.
- R9: `mode_sel`=3 holds both outputs low. Leaving a mode and coming back restarts the period counter and the fractional phase from zero.
- R10: `os_tick` pulses only in asynchronous mode, and `sclk_out` is low in asynchronous mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | 0 async, 1 sync master, 2 sync slave, 3 off |
| wr_en | input | 1 | Divisor register write strobe |
| wr_sel | input | 2 | Register select: 0 low byte, 1 high byte, 2 fraction |
| wr_data | input | 8 | Write data |
| ext_sclk | input | 1 | External serial clock used in slave mode |
| os_tick | output | 1 | 16x oversampling strobe (async mode) |
| sclk_out | output | 1 | Generated or forwarded serial clock |

## Verification
Two situations are hard to reach from the ports. The first is a divisor rewrite that lands inside a running period. The bench waits until it sees a tick or a clock edge and issues the write on the very next cycle. It then measures the period in flight, which must keep the old length, and the period after it, which must take the new length. The second is the carry pattern of the fractional phase. Every fraction value from 0 to 63 is swept with two small whole divisors over a full 64-period cycle, and each spacing is compared with the floor-difference formula.

// File: rtl/fb_pkg.sv
package fb_pkg;
   typedef enum logic [1:0] {
      MODE_ASYNC  = 2'b00,
      MODE_MASTER = 2'b01,
      MODE_SLAVE  = 2'b10,
      MODE_OFF    = 2'b11
   } fb_mode_e;

   localparam logic [1:0] SEL_INT_LO = 2'd0;
   localparam logic [1:0] SEL_INT_HI = 2'd1;
   localparam logic [1:0] SEL_FRAC   = 2'd2;
endpackage

// File: rtl/fb_div_regs.sv
module fb_div_regs
   import fb_pkg::*;
#(
   parameter int INT_W  = 16,
   parameter int FRAC_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [7:0]        wr_data,
   output logic [INT_W-1:0]  int_div,
   output logic [FRAC_W-1:0] frac
);
   localparam int HI_W = INT_W - 8;

   generate
      if (INT_W < 9 || INT_W > 16) begin : g_bad_int
         $error("fb_div_regs: INT_W must lie in 9..16");
      end
      if (FRAC_W < 1 || FRAC_W > 8) begin : g_bad_frac
         $error("fb_div_regs: FRAC_W must lie in 1..8");
      end
   endgenerate

   logic [7:0]        lo_q;
   logic [HI_W-1:0]   hi_q;
   logic [FRAC_W-1:0] frac_q;

   // R2: byte-wise divisor load, select 3 writes nothing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         frac_q <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_INT_LO: lo_q   <= wr_data;
            SEL_INT_HI: hi_q   <= wr_data[HI_W-1:0];
            SEL_FRAC:   frac_q <= wr_data[FRAC_W-1:0];
            default:    ;
         endcase
      end
   end

   assign int_div = {hi_q, lo_q};
   assign frac    = frac_q;
endmodule

// File: rtl/fb_period_ctr.sv
module fb_period_ctr #(
   parameter int INT_W  = 16,
   parameter int FRAC_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              frac_en,
   input  logic [INT_W-1:0]  int_div,
   input  logic [FRAC_W-1:0] frac,
   output logic              period_end
);
   localparam int CW = INT_W + 1;

   logic [CW-1:0]     cnt_q;
   logic [CW-1:0]     per_q;
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   acc_sum;
   logic [CW-1:0]     base_per;
   logic              use_frac;

   assign acc_sum    = {1'b0, acc_q} + {1'b0, frac};
   assign base_per   = {1'b0, int_div};
   assign use_frac   = frac_en && (int_div > INT_W'(1));
   assign period_end = (per_q != '0) && (cnt_q == per_q - CW'(1));

   // Period register is reloaded only at a boundary (R7); a carry from
   // the phase accumulator stretches the next period by one cycle (R3).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         per_q <= '0;
         acc_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
         per_q <= '0;
         acc_q <= '0;
      end else if (per_q == '0) begin
         cnt_q <= '0;
         per_q <= base_per;
      end else if (period_end) begin
         cnt_q <= '0;
         if (use_frac) begin
            acc_q <= acc_sum[FRAC_W-1:0];
            per_q <= base_per + CW'(acc_sum[FRAC_W]);
         end else begin
            per_q <= base_per;
         end
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   p_cnt_below_per_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (per_q != '0) |-> (cnt_q < per_q));

   p_load_choice_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && period_end) |=>
         (per_q == {1'b0, $past(int_div)} || per_q == {1'b0, $past(int_div)} + CW'(1)));

   p_no_frac_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && period_end && !frac_en) |=> (per_q == {1'b0, $past(int_div)}));

   p_unit_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && period_end && int_div == INT_W'(1)) |=> (per_q == CW'(1)));

   p_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (per_q == '0 && int_div == '0) |=> (per_q == '0));
endmodule

// File: rtl/fb_clk_sync.sv
module fb_clk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("fb_clk_sync: STAGES must lie in 0..4");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= (sh_q << 1) | STAGES'(d);
         end
         assign q = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/fracbaud_gen.sv
module fracbaud_gen
   import fb_pkg::*;
#(
   parameter int INT_W       = 16,
   parameter int FRAC_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_sel,
   input  logic       wr_en,
   input  logic [1:0] wr_sel,
   input  logic [7:0] wr_data,
   input  logic       ext_sclk,
   output logic       os_tick,
   output logic       sclk_out
);
   fb_mode_e          mode_now;
   fb_mode_e          mode_q;
   logic              run;
   logic              frac_en;
   logic              period_end;
   logic              ext_sync;
   logic [INT_W-1:0]  int_div;
   logic [FRAC_W-1:0] frac;
   logic              tick_q;
   logic              sclk_q;

   assign mode_now = fb_mode_e'(mode_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_OFF;
      else        mode_q <= mode_now;
   end

   // R9: one idle cycle on any mode change restarts counter and phase
   assign run     = (mode_now == MODE_ASYNC || mode_now == MODE_MASTER) && (mode_now == mode_q);
   assign frac_en = (mode_now == MODE_ASYNC);

   fb_div_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .int_div (int_div),
      .frac    (frac)
   );

   fb_period_ctr #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .frac_en    (frac_en),
      .int_div    (int_div),
      .frac       (frac),
      .period_end (period_end)
   );

   fb_clk_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_sclk),
      .q     (ext_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= 1'b0;
         sclk_q <= 1'b0;
      end else begin
         tick_q <= period_end && run && (mode_now == MODE_ASYNC);
         case (mode_now)
            MODE_MASTER: begin
               if (!run)            sclk_q <= 1'b0;
               else if (period_end) sclk_q <= ~sclk_q;
            end
            MODE_SLAVE: sclk_q <= ext_sync;
            default:    sclk_q <= 1'b0;
         endcase
      end
   end

   assign os_tick  = tick_q;
   assign sclk_out = sclk_q;

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!os_tick && !sclk_out));

   p_tick_async_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      os_tick |-> ($past(mode_sel) == MODE_ASYNC));

   p_sclk_low_async_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_sel) == MODE_ASYNC) |-> !sclk_out);

   p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_sel) == MODE_OFF) |-> (!sclk_out && !os_tick));

   p_slave_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_sel) == MODE_SLAVE) |-> !os_tick);
endmodule

// File: tb/test_fracbaud_gen.sv
module test_fracbaud_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'd2;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       ext_sclk = 1'b0;
   logic       os_tick;
   logic       sclk_out;

   always #5 clk = ~clk;

   fracbaud_gen i_fracbaud_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_sel (mode_sel),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .ext_sclk (ext_sclk),
      .os_tick  (os_tick),
      .sclk_out (sclk_out)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int fails  = 0;
   int ev_t [0:255];
   int ev_n;
   bit other_bad;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_div(input int d, input int f);
      mode_sel = 2'd2;
      wr(2'd0, 8'(d & 255));
      wr(2'd1, 8'((d >> 8) & 255));
      wr(2'd2, 8'(f & 255));
   endtask

   // kind 0: os_tick pulses; kind 1: sclk_out edges
   task automatic capture(input int kind, input int n, input int limit);
      logic prev;
      ev_n = 0; other_bad = 1'b0; prev = sclk_out;
      for (int c = 0; c < limit && ev_n < n; c++) begin
         @(negedge clk);
         if (kind == 0 ? os_tick : (sclk_out != prev)) begin
            ev_t[ev_n] = cyc;
            ev_n++;
         end
         if (kind == 0 && sclk_out) other_bad = 1'b1;
         if (kind == 1 && os_tick)  other_bad = 1'b1;
         prev = sclk_out;
      end
   endtask

   task automatic check_intervals(input int d, input int f, input int n, input bit dither,
                                  input string req);
      bit ok;
      int ba, be;
      ok = (ev_n == n + 1); ba = ev_n; be = n + 1;
      if (ok) begin
         for (int k = 1; k <= n; k++) begin
            int e, a;
            e = dither ? d + ((k * f) >> 6) - (((k - 1) * f) >> 6) : d;
            a = ev_t[k] - ev_t[k-1];
            if (ok && a != e) begin ok = 1'b0; ba = a; be = e; end
         end
      end
      chk(ok, req, ba, be);
   endtask

   task automatic async_run(input int d, input int fbyte, input int n, input string req);
      set_div(d, fbyte);
      mode_sel = 2'd0;
      capture(0, n + 1, (n + 2) * (d + 2) + 40);
      check_intervals(d, fbyte & 63, n, d > 1, req);
      chk(!other_bad, "R10 sclk_out low in async", int'(other_bad), 0);
   endtask

   task automatic master_run(input int d, input int f, input int n);
      set_div(d, f);
      mode_sel = 2'd1;
      capture(1, n + 1, (n + 2) * (d + 2) + 40);
      check_intervals(d, 0, n, 1'b0, "R6 master half period");
      chk(!other_bad, "R10 no tick in master", int'(other_bad), 0);
   endtask

   task automatic finish_up;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_up();
   end

   initial begin
      int t0;
      bit bad;
      logic hist [0:63];

      // R1: outputs quiet during reset, even in async mode
      mode_sel = 2'd0;
      bad = 1'b0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (os_tick || sclk_out) bad = 1'b1;
      end
      chk(!bad, "R1 outputs low in reset", int'(bad), 0);
      rst_n = 1'b1;
      capture(0, 1, 40);
      chk(ev_n == 0, "R1 no tick with cleared divisor", ev_n, 0);

      // R3: full fraction sweep over a complete 64-phase cycle
      for (int d = 2; d <= 3; d++)
         for (int f = 0; f < 64; f++)
            async_run(d, f, 64, "R3 fractional spacing");

      // R4: unit divisor ignores fraction
      async_run(1, 37, 20, "R4 unit divisor");

      // R2: high byte, dropped fraction bits, select 3 ignored
      async_run(3, 8'hC5, 20, "R2 fraction uses low 6 bits");
      set_div(258, 5);
      wr(2'd3, 8'hFF);
      mode_sel = 2'd0;
      capture(0, 7, 7 * 270);
      check_intervals(258, 5, 6, 1'b1, "R2 16-bit divisor and select 3 ignored");

      // R5: zero divisor
      set_div(0, 10);
      mode_sel = 2'd0;
      capture(0, 1, 80);
      chk(ev_n == 0, "R5 no tick with zero divisor", ev_n, 0);
      mode_sel = 2'd1;
      capture(1, 1, 80);
      chk(ev_n == 0 && !sclk_out, "R5 master clock idle with zero divisor", ev_n, 0);

      // R6: master clock ignores fraction
      master_run(3, 40, 12);
      master_run(7, 0, 6);

      // R7: async rewrite one cycle after a tick
      set_div(4, 0);
      mode_sel = 2'd0;
      capture(0, 1, 40);
      t0 = ev_t[0];
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'd7;
      @(negedge clk);
      wr_en = 1'b0;
      capture(0, 2, 40);
      chk(ev_n == 2 && ev_t[0] - t0 == 4, "R7 period in flight keeps old divisor", ev_t[0] - t0, 4);
      chk(ev_n == 2 && ev_t[1] - ev_t[0] == 7, "R7 next period uses new divisor", ev_t[1] - ev_t[0], 7);

      // R7: master rewrite one cycle after an edge
      set_div(3, 0);
      mode_sel = 2'd1;
      capture(1, 1, 40);
      t0 = ev_t[0];
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'd5;
      @(negedge clk);
      wr_en = 1'b0;
      capture(1, 2, 40);
      chk(ev_n == 2 && ev_t[0] - t0 == 3, "R7 master half period in flight", ev_t[0] - t0, 3);
      chk(ev_n == 2 && ev_t[1] - ev_t[0] == 5, "R7 master new half period", ev_t[1] - ev_t[0], 5);

      // R8: slave forwarding with a 3-cycle delay
      mode_sel = 2'd2;
      repeat (4) @(negedge clk);
      bad = 1'b0;
      t0 = 0;
      for (int j = 0; j < 60; j++) begin
         @(negedge clk);
         if (j >= 3 && sclk_out != hist[j-3]) begin bad = 1'b1; t0 = j; end
         if (os_tick) bad = 1'b1;
         hist[j] = 1'(((j * 13) >> 2) & 1) ^ 1'(j % 5 == 0);
         ext_sclk = hist[j];
      end
      chk(!bad, "R8 slave clock delayed copy", t0, 0);

      // R9: reserved mode quiet
      set_div(2, 0);
      mode_sel = 2'd3;
      capture(0, 1, 60);
      chk(ev_n == 0 && !other_bad, "R9 off mode quiet", ev_n, 0);

      // R9: phase restarts after leaving and re-entering async
      set_div(3, 21);
      mode_sel = 2'd0;
      capture(0, 11, 200);
      mode_sel = 2'd1;
      repeat (5) @(negedge clk);
      mode_sel = 2'd0;
      capture(0, 17, 200);
      check_intervals(3, 21, 16, 1'b1, "R9 phase restarts on re-entry");

      // R1: reset in mid-run clears outputs and divisor
      set_div(2, 0);
      mode_sel = 2'd1;
      repeat (9) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!os_tick && !sclk_out, "R1 outputs cleared by reset", int'(sclk_out), 0);
      rst_n = 1'b1;
      mode_sel = 2'd0;
      capture(0, 1, 40);
      chk(ev_n == 0, "R1 divisor cleared by reset", ev_n, 0);

      finish_up();
   end
endmodule